// File: doc/BRIEF.md
# Dispatch Group Slot Allocator

This block sits at the end of the decode stage of a wide out-of-order core. Each cycle it sees a group of up to six decoded micro-ops in program order. Every op carries a three-bit dispatch class, and each class names a short, ordered menu of port combinations it may occupy. There are ten dispatch ports: four slice ports, a third-slot pair for each of the two superslices, and two branch ports. The allocator walks the group from the oldest op forward. For each op it takes the first menu entry whose ports are all still free in this cycle. The group ends at the first op that does not fit.

The result is registered and appears one clock after the group is presented. It consists of a grant count and, for each granted op, a ten-bit bitmap of the ports it holds. Ops at or beyond the grant count are not dispatched, and the upstream stage presents them again in the next cycle. Port occupancy is rebuilt from nothing for every group.

Top module: `dispatch_slot_alloc`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are a grant count of 0 and all port bitmaps 0, whatever the inputs are.
- R2: The outputs change only at rising edges. They show the allocation of the group sampled at the previous edge, so changing an input between edges leaves them unchanged.
- R3: Port bitmap bits are: bit0..3 slice ports s0..s3, bit4/5 third slot A halves a0/a1, bit6/7 third slot B halves b0/b1, bit8/9 branch ports r0/r1. Class code 0 (single) tries, in this order: s0, s1, s2, s3, {a0,a1}, {b0,b1}.
- R4: Class code 1 (slice pair) tries {s0,s1} then {s2,s3}.
- R5: Class code 2 (slice with third slot) tries {s0,a0}, {s1,a1}, {s2,b0}, {s3,b1}.
- R6: Class code 3 (two-way split) tries {s0,s1}, {s1,a0,a1}, {s1,s2}, {a0,a1,s2}, {s2,s3}, {s3,b0,b1}.
- R7: Class code 4 (two-way split with third slot) tries {s0,s1,a0}, {s1,s2,a0}, {s1,s2,b0}, {s2,s3,b0}.
- R8: Class code 5 (three-way split) needs all ten ports. It is granted only as the first op of a group, and nothing else is granted in that cycle.
- R9: Class code 6 (branch) tries r0 then r1. At most two branch-class ops are granted per cycle.
- R10: Grants form a strict in-order prefix. The first op that cannot be placed is not granted, and neither is any later op, even one that would fit. The count equals the index of that op. Class code 7 is reserved and is never placed.
- R11: Only the first `in_count` ops are considered. No port appears in the bitmaps of two granted ops, and every op at or beyond the grant count has a zero bitmap.
- R12: A third-slot pair option of classes 0 and 3 is unavailable once either of its halves is taken by an earlier op in the group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_count | input | 3 | Number of valid ops in the group (0..6) |
| in_class | input | 18 | Class code of op i in bits [3i+2:3i] |
| gnt_count | output | 3 | Number of ops granted (0..6), registered |
| gnt_ports | output | 60 | Port bitmap of op i in bits [10i+9:10i], registered |

## Verification
The bench goes after menu order first. A design that tried a later entry before an earlier one would place ops on the wrong ports even when the count is right. It also targets the third-slot halves: a design that treated a pair as free once one half was taken would hand a port to two ops. The in-order stop is tested with a blocked op followed by one that would fit. A design that skipped the blocked op would report too high a count and a non-zero tail bitmap. The whole-cycle class is tested both at the head and behind another op. Every combination of the first three classes is swept, followed by a long pseudo-random run of full groups that is compared against an arithmetic model.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

    localparam int PORT_W   = 10;
    localparam int MENU_MAX = 6;
    localparam int CLS_W    = 3;

    typedef logic [PORT_W-1:0] port_mask_t;

    typedef enum logic [CLS_W-1:0] {
        CL_SINGLE = 3'd0,
        CL_PAIR   = 3'd1,
        CL_SL3    = 3'd2,
        CL_SPLIT2 = 3'd3,
        CL_SPL2T  = 3'd4,
        CL_SPLIT3 = 3'd5,
        CL_BRANCH = 3'd6,
        CL_RSVD   = 3'd7
    } op_class_e;

    localparam port_mask_t PS0 = 10'h001;
    localparam port_mask_t PS1 = 10'h002;
    localparam port_mask_t PS2 = 10'h004;
    localparam port_mask_t PS3 = 10'h008;
    localparam port_mask_t PA0 = 10'h010;
    localparam port_mask_t PA1 = 10'h020;
    localparam port_mask_t PB0 = 10'h040;
    localparam port_mask_t PB1 = 10'h080;
    localparam port_mask_t PR0 = 10'h100;
    localparam port_mask_t PR1 = 10'h200;
    localparam port_mask_t PA  = PA0 | PA1;
    localparam port_mask_t PB  = PB0 | PB1;

    // Ordered menu of port combinations; an empty mask marks an unused entry.
    function automatic port_mask_t menu_entry(op_class_e c, int unsigned k);
        port_mask_t m;
        m = '0;
        case (c)
            CL_SINGLE: case (k)
                0: m = PS0;
                1: m = PS1;
                2: m = PS2;
                3: m = PS3;
                4: m = PA;
                5: m = PB;
                default: m = '0;
            endcase
            CL_PAIR: case (k)
                0: m = PS0 | PS1;
                1: m = PS2 | PS3;
                default: m = '0;
            endcase
            CL_SL3: case (k)
                0: m = PS0 | PA0;
                1: m = PS1 | PA1;
                2: m = PS2 | PB0;
                3: m = PS3 | PB1;
                default: m = '0;
            endcase
            CL_SPLIT2: case (k)
                0: m = PS0 | PS1;
                1: m = PS1 | PA;
                2: m = PS1 | PS2;
                3: m = PA  | PS2;
                4: m = PS2 | PS3;
                5: m = PS3 | PB;
                default: m = '0;
            endcase
            CL_SPL2T: case (k)
                0: m = PS0 | PS1 | PA0;
                1: m = PS1 | PS2 | PA0;
                2: m = PS1 | PS2 | PB0;
                3: m = PS2 | PS3 | PB0;
                default: m = '0;
            endcase
            CL_SPLIT3: m = (k == 0) ? '1 : '0;
            CL_BRANCH: case (k)
                0: m = PR0;
                1: m = PR1;
                default: m = '0;
            endcase
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dsa_slot_pick.sv
module dsa_slot_pick
    import dsa_pkg::*;
(
    input  logic       alive,
    input  op_class_e  cls,
    input  port_mask_t busy_in,
    output logic       placed,
    output port_mask_t take,
    output port_mask_t busy_out
);

    port_mask_t          cand [MENU_MAX];
    logic [MENU_MAX-1:0] fits;

    for (genvar k = 0; k < MENU_MAX; k++) begin : g_cand
        assign cand[k] = menu_entry(cls, k);
        assign fits[k] = (cand[k] != '0) && ((cand[k] & busy_in) == '0);
    end

    // Lowest-numbered fitting entry wins.
    always_comb begin
        take = '0;
        for (int k = MENU_MAX - 1; k >= 0; k--) begin
            if (fits[k]) take = cand[k];
        end
        if (!alive) take = '0;
    end

    assign placed   = alive && (|fits);
    assign busy_out = busy_in | take;

endmodule

// File: rtl/dsa_out_reg.sv
module dsa_out_reg
    import dsa_pkg::*;
#(
    parameter int NUM_OPS = 6,
    parameter int CNT_W   = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [CNT_W-1:0]          cnt_d,
    input  logic [NUM_OPS*PORT_W-1:0] ports_d,
    output logic [CNT_W-1:0]          cnt_q,
    output logic [NUM_OPS*PORT_W-1:0] ports_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            ports_q <= '0;
        end else begin
            cnt_q   <= cnt_d;
            ports_q <= ports_d;
        end
    end

endmodule

// File: rtl/dispatch_slot_alloc.sv
module dispatch_slot_alloc
    import dsa_pkg::*;
#(
    parameter  int NUM_OPS = 6,
    localparam int CNT_W   = $clog2(NUM_OPS + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [CNT_W-1:0]          in_count,
    input  logic [NUM_OPS*CLS_W-1:0]  in_class,
    output logic [CNT_W-1:0]          gnt_count,
    output logic [NUM_OPS*PORT_W-1:0] gnt_ports
);

    logic [NUM_OPS-1:0]        placed;
    port_mask_t                busy  [NUM_OPS+1];
    port_mask_t                take  [NUM_OPS];
    logic [CNT_W-1:0]          cnt_d;
    logic [NUM_OPS*PORT_W-1:0] ports_d;

    assign busy[0] = '0;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
        logic alive;
        if (i == 0) begin : g_head
            assign alive = in_count > CNT_W'(i);
        end else begin : g_tail
            assign alive = placed[i-1] && (in_count > CNT_W'(i));
        end

        dsa_slot_pick u_pick (
            .alive    (alive),
            .cls      (op_class_e'(in_class[i*CLS_W +: CLS_W])),
            .busy_in  (busy[i]),
            .placed   (placed[i]),
            .take     (take[i]),
            .busy_out (busy[i+1])
        );

        assign ports_d[i*PORT_W +: PORT_W] = take[i];
    end

    // Placement stops at the first miss, so the popcount is the prefix length.
    always_comb begin
        cnt_d = '0;
        for (int i = 0; i < NUM_OPS; i++) begin
            cnt_d = cnt_d + CNT_W'(placed[i]);
        end
    end

    dsa_out_reg #(
        .NUM_OPS (NUM_OPS),
        .CNT_W   (CNT_W)
    ) u_out (
        .clk     (clk),
        .rst     (rst),
        .cnt_d   (cnt_d),
        .ports_d (ports_d),
        .cnt_q   (gnt_count),
        .ports_q (gnt_ports)
    );

endmodule

// File: rtl/dsa_alloc_chk.sv
module dsa_alloc_chk
    import dsa_pkg::*;
#(
    parameter  int NUM_OPS = 6,
    localparam int CNT_W   = $clog2(NUM_OPS + 1)
) (
    input logic                      clk,
    input logic                      rst,
    input logic [CNT_W-1:0]          in_count,
    input logic [CNT_W-1:0]          gnt_count,
    input logic [NUM_OPS*PORT_W-1:0] gnt_ports
);

    logic overlap;
    logic tail_dirty;
    logic whole_seen;

    always_comb begin
        port_mask_t acc;
        acc        = '0;
        overlap    = 1'b0;
        tail_dirty = 1'b0;
        whole_seen = 1'b0;
        for (int i = 0; i < NUM_OPS; i++) begin
            port_mask_t m;
            m = gnt_ports[i*PORT_W +: PORT_W];
            if ((m & acc) != '0) overlap = 1'b1;
            acc = acc | m;
            if ((CNT_W'(i) >= gnt_count) && (m != '0)) tail_dirty = 1'b1;
            if (m == '1) whole_seen = 1'b1;
        end
    end

    a_r11_ports_disjoint: assert property (@(posedge clk) disable iff (rst)
        !overlap);

    a_r10_tail_clear: assert property (@(posedge clk) disable iff (rst)
        !tail_dirty);

    a_r8_whole_cycle_alone: assert property (@(posedge clk) disable iff (rst)
        whole_seen |-> (gnt_count == CNT_W'(1)));

    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (gnt_count <= $past(in_count)));

endmodule

bind dispatch_slot_alloc dsa_alloc_chk #(.NUM_OPS(NUM_OPS)) u_dsa_chk (
    .clk       (clk),
    .rst       (rst),
    .in_count  (in_count),
    .gnt_count (gnt_count),
    .gnt_ports (gnt_ports)
);

// File: tb/test_dispatch_slot_alloc.sv
module test_dispatch_slot_alloc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  in_count = '0;
    logic [17:0] in_class = '0;
    logic [2:0]  gnt_count;
    logic [59:0] gnt_ports;

    int n_checks = 0;
    int n_err    = 0;

    int         exp_cnt;
    logic [9:0] exp_m [6];

    always #5 clk = ~clk;

    dispatch_slot_alloc i_dispatch_slot_alloc (
        .clk       (clk),
        .rst       (rst),
        .in_count  (in_count),
        .in_class  (in_class),
        .gnt_count (gnt_count),
        .gnt_ports (gnt_ports)
    );

    function automatic logic [17:0] pk(int c0, int c1, int c2, int c3, int c4, int c5);
        return {c5[2:0], c4[2:0], c3[2:0], c2[2:0], c1[2:0], c0[2:0]};
    endfunction

    // Menus written as packed hex rows, entry k at bits [10k+9:10k].
    function automatic logic [9:0] opt_of(int c, int k);
        logic [59:0] row;
        case (c)
            0: row = {10'h0C0, 10'h030, 10'h008, 10'h004, 10'h002, 10'h001};
            1: row = {10'h000, 10'h000, 10'h000, 10'h000, 10'h00C, 10'h003};
            2: row = {10'h000, 10'h000, 10'h088, 10'h044, 10'h022, 10'h011};
            3: row = {10'h0C8, 10'h00C, 10'h034, 10'h006, 10'h032, 10'h003};
            4: row = {10'h000, 10'h000, 10'h04C, 10'h046, 10'h016, 10'h013};
            5: row = {10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 10'h3FF};
            6: row = {10'h000, 10'h000, 10'h000, 10'h000, 10'h200, 10'h100};
            default: row = '0;
        endcase
        return row[k*10 +: 10];
    endfunction

    function automatic string tag_of(int c);
        case (c)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            6: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic ref_alloc(input int n, input logic [17:0] cls);
        logic [9:0] used;
        bit         stop;
        used    = '0;
        stop    = 1'b0;
        exp_cnt = 0;
        for (int i = 0; i < 6; i++) begin
            exp_m[i] = '0;
            if (!stop && i < n) begin
                bit found;
                found = 1'b0;
                for (int k = 0; k < 6; k++) begin
                    logic [9:0] o;
                    o = opt_of(int'(cls[i*3 +: 3]), k);
                    if (!found && o != '0 && (o & used) == '0) begin
                        found    = 1'b1;
                        exp_m[i] = o;
                        used     = used | o;
                    end
                end
                if (found) exp_cnt++;
                else stop = 1'b1;
            end else begin
                stop = 1'b1;
            end
        end
    endtask

    task automatic chk(input string tag, input string what, input logic [9:0] act, input logic [9:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic chk_cnt(input string tag, input int exp);
        chk(tag, "count", {7'b0, gnt_count}, exp[9:0]);
    endtask

    task automatic chk_op(input string tag, input int i, input logic [9:0] exp);
        chk(tag, $sformatf("op%0d bitmap", i), gnt_ports[i*10 +: 10], exp);
    endtask

    // Drive at a falling edge; the result is registered at the next rising edge
    // and sampled at the falling edge after it.
    task automatic apply(input int n, input logic [17:0] cls);
        @(negedge clk);
        in_count = n[2:0];
        in_class = cls;
        @(negedge clk);
    endtask

    task automatic apply_ref(input int n, input logic [17:0] cls);
        apply(n, cls);
        ref_alloc(n, cls);
        chk_cnt("R10", exp_cnt);
        for (int i = 0; i < 6; i++) begin
            chk_op(tag_of(int'(cls[i*3 +: 3])), i, exp_m[i]);
        end
    endtask

    initial begin
        #(10 * 150000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] lf;

        // R1: reset dominates a full group on the inputs
        in_count = 3'd6;
        in_class = pk(0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk_cnt("R1", 0);
        chk("R1", "all bitmaps", {9'b0, (gnt_ports != '0)}, 10'h0);
        rst = 1'b0;

        // R3: single-port class in menu order
        apply(6, pk(0, 0, 0, 0, 0, 0));
        chk_cnt("R3", 6);
        chk_op("R3", 0, 10'h001); chk_op("R3", 1, 10'h002); chk_op("R3", 2, 10'h004);
        chk_op("R3", 3, 10'h008); chk_op("R3", 4, 10'h030); chk_op("R3", 5, 10'h0C0);

        // R2: an input change between edges leaves outputs alone
        @(negedge clk);
        in_count = 3'd0;
        #1;
        chk_cnt("R2", 6);
        @(negedge clk);
        chk_cnt("R2", 0);

        // R11: only in_count ops are considered
        apply(3, pk(0, 0, 0, 0, 0, 0));
        chk_cnt("R11", 3);
        chk_op("R11", 3, 10'h000); chk_op("R11", 5, 10'h000);

        // R4: slice pairs, third does not fit
        apply(3, pk(1, 1, 1, 0, 0, 0));
        chk_cnt("R4", 2);
        chk_op("R4", 0, 10'h003); chk_op("R4", 1, 10'h00C); chk_op("R4", 2, 10'h000);

        // R5: slice with third slot fills every slice
        apply(5, pk(2, 2, 2, 2, 0, 0));
        chk_cnt("R5", 4);
        chk_op("R5", 1, 10'h022); chk_op("R5", 2, 10'h044); chk_op("R5", 3, 10'h088);

        // R12: half of pair A taken, single class falls through to pair B
        apply(5, pk(2, 0, 0, 0, 0, 0));
        chk_cnt("R12", 5);
        chk_op("R12", 1, 10'h002); chk_op("R12", 4, 10'h0C0);

        // R12: split class skips the pair-A option
        apply(2, pk(2, 3, 0, 0, 0, 0));
        chk_op("R12", 1, 10'h006);

        // R6: two-way split walk
        apply(4, pk(3, 3, 3, 3, 0, 0));
        chk_cnt("R6", 3);
        chk_op("R6", 0, 10'h003); chk_op("R6", 1, 10'h034); chk_op("R6", 2, 10'h0C8);

        // R7: two-way split with third slot
        apply(3, pk(4, 4, 4, 0, 0, 0));
        chk_cnt("R7", 2);
        chk_op("R7", 0, 10'h013); chk_op("R7", 1, 10'h04C);

        // R8: whole-cycle class at the head and behind another op
        apply(3, pk(5, 0, 6, 0, 0, 0));
        chk_cnt("R8", 1);
        chk_op("R8", 0, 10'h3FF); chk_op("R8", 1, 10'h000);
        apply(2, pk(0, 5, 0, 0, 0, 0));
        chk_cnt("R8", 1);
        chk_op("R8", 0, 10'h001); chk_op("R8", 1, 10'h000);

        // R9 and R10: third branch stops the group although a slice is free
        apply(4, pk(6, 6, 6, 0, 0, 0));
        chk_cnt("R9", 2);
        chk_op("R9", 0, 10'h100); chk_op("R9", 1, 10'h200);
        chk_op("R10", 3, 10'h000);

        // R10: reserved code never placed
        apply(2, pk(7, 0, 0, 0, 0, 0));
        chk_cnt("R10", 0);
        chk_op("R10", 1, 10'h000);

        // Exhaustive over the first three classes
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                for (int c = 0; c < 8; c++)
                    apply_ref(3, pk(a, b, c, 0, 6, 6));

        // Pseudo-random groups
        lf = 32'h1D2C_3B4A;
        for (int t = 0; t < 3000; t++) begin
            lf = lf ^ (lf << 13);
            lf = lf ^ (lf >> 17);
            lf = lf ^ (lf << 5);
            apply_ref(int'(lf[31:29]) % 7, lf[17:0]);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule